// File: doc/BRIEF.md
# Dual-Channel Dynamic-TOP PWM Controller

This block generates the drive waveforms for a two-string linear LED driver with an extra direct-drive switch on the first string. The two linear outputs share one up/down counter. It counts from zero up to a TOP value that can be changed at run time, then back down to zero, so the PWM frequency and resolution follow TOP. The direct-drive output has its own free-running 8-bit up/down counter with a fixed TOP of 255. Two amplifier-enable outputs switch the linear current regulators on and off. They are never used to set brightness.

The requester presents three duty values and a new TOP on a valid/ready handshake. The block classifies each request against the compare values currently applied. A request with all three duties zero turns the light off. Leaving the fully-off state is a turn-on. Any other request is a level change. Turn-off and turn-on reset the counter phase. A level change that would lower TOP while the counter is still near its new peak is held back, with ready low, until the counter has fallen far enough. This prevents the counter from overshooting the new TOP.

Top module: `dualch_pwm_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, every PWM output and both amplifier enables are low and `req_ready` is high.
- R2: The shared counter steps 0, 1, …, TOP, TOP−1, …, 1 and repeats with a period of 2·TOP cycles. A linear output is high in the cycle after the counter is below its compare value, so a compare value C with 0 < C < TOP gives 2·C−1 high cycles in every run of 2·TOP consecutive cycles.
- R3: A linear compare value of zero holds its output low. A compare value greater than or equal to TOP holds it high.
- R4: The direct-drive output uses its own free-running up/down counter with TOP fixed at 255 and a period of 510 cycles. A compare value C in 1..254 gives 2·C−1 high cycles per period, 255 holds it high, and 0 holds it low.
- R5: Each amplifier enable is high exactly when the applied compare value of its linear channel is nonzero. It changes in the same cycle as the compare values.
- R6: An accepted request whose three duty values are all zero applies the following in the acceptance cycle: all compare values become zero, TOP becomes 255, the shared counter is cleared and both enables go low. All outputs are low from the second cycle after acceptance.
- R7: A request accepted while all applied compare values are zero (turn-on) is applied in the acceptance cycle with the shared counter cleared. A linear output with nonzero duty is therefore high in the first cycle after acceptance.
- R8: A request accepted while some applied compare value is nonzero (level change) is applied in the acceptance cycle without touching the counter phase if the counter is at or below the new TOP minus 32 (taken as 0 when the new TOP is below 32). `req_ready` then stays high.
- R9: Otherwise a level change drives `req_ready` low and leaves the old values in force. It applies the held values in the first cycle in which the counter is at or below that limit, and `req_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_duty_a | input | CNT_W | Compare value for linear channel A |
| req_duty_b | input | CNT_W | Compare value for linear channel B |
| req_duty_fet | input | FET_W | Compare value for the direct-drive channel |
| req_top | input | CNT_W | New TOP for the shared counter |
| pwm_a | output | 1 | Linear channel A PWM |
| pwm_b | output | 1 | Linear channel B PWM |
| pwm_fet | output | 1 | Direct-drive PWM |
| amp_en_a | output | 1 | Amplifier enable, channel A |
| amp_en_b | output | 1 | Amplifier enable, channel B |

## Verification
The bench tracks the shared counter's phase from the turn-on edge and times a TOP reduction requested on the rising slope. A design that applied it at once, judged the limit wrongly or cleared the counter on a level change would release `req_ready` in a different cycle. Duty windows of exactly one period catch off-by-one compare senses and a missing constant-high case at compare ≥ TOP. Turn-off and a second turn-on check that all outputs go low and that the phase restarts, so the first post-acceptance cycle is high.

// File: rtl/dualch_pwm_pkg.sv
package dualch_pwm_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1
  } seq_state_e;

  typedef enum logic [1:0] {
    APPLY_NONE  = 2'd0,
    APPLY_OFF   = 2'd1,
    APPLY_REQ   = 2'd2,
    APPLY_PEND  = 2'd3
  } apply_sel_e;

endpackage

// File: rtl/lpc_updown_counter.sv
module lpc_updown_counter
  import dualch_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  cnt_dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= ZERO;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt >= top) begin
        // peak reached: turn around
        dir_q <= DIR_DOWN;
        cnt   <= (cnt == ZERO) ? ZERO : cnt - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (cnt == ZERO) begin
        // valley reached: turn around
        dir_q <= DIR_UP;
        cnt   <= (top == ZERO) ? ZERO : ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/lpc_cmp_out.sv
module lpc_cmp_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] top,
  output logic         pwm
);

  logic active;
  logic full_on;
  logic below;

  always_comb begin
    active  = (cmp != '0);
    full_on = (cmp >= top);
    below   = (cnt < cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
    end else begin
      pwm <= active && (full_on || below);
    end
  end

endmodule

// File: rtl/lpc_req_seq.sv
module lpc_req_seq
  import dualch_pwm_pkg::*;
#(
  parameter int CW       = 16,
  parameter int FW       = 8,
  parameter int TOP_INIT = 255,
  parameter int GUARD    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_duty_a,
  input  logic [CW-1:0] req_duty_b,
  input  logic [FW-1:0] req_duty_f,
  input  logic [CW-1:0] req_top,
  input  logic [CW-1:0] cnt_now,
  output logic [CW-1:0] cmp_a,
  output logic [CW-1:0] cmp_b,
  output logic [FW-1:0] cmp_f,
  output logic [CW-1:0] top_q,
  output logic          en_a,
  output logic          en_b,
  output logic          cnt_clr
);

  localparam logic [CW-1:0] TOP_RST = CW'(TOP_INIT);
  localparam logic [CW-1:0] GUARD_V = CW'(GUARD);

  function automatic logic [CW-1:0] hold_limit(input logic [CW-1:0] t);
    return (t >= GUARD_V) ? (t - GUARD_V) : '0;
  endfunction

  seq_state_e    state_q;
  logic [CW-1:0] pend_a;
  logic [CW-1:0] pend_b;
  logic [FW-1:0] pend_f;
  logic [CW-1:0] pend_top;

  logic          accept;
  logic          req_off;
  logic          lit;
  logic          safe_req;
  logic          safe_pend;
  logic          go_hold;
  apply_sel_e    sel;

  always_comb begin
    req_ready = (state_q == SEQ_IDLE);
    accept    = req_valid && req_ready;
    req_off   = (req_duty_a == '0) && (req_duty_b == '0) && (req_duty_f == '0);
    lit       = (cmp_a != '0) || (cmp_b != '0) || (cmp_f != '0);
    safe_req  = (cnt_now <= hold_limit(req_top));
    safe_pend = (cnt_now <= hold_limit(pend_top));
    sel       = APPLY_NONE;
    cnt_clr   = 1'b0;
    go_hold   = 1'b0;
    if (accept) begin
      if (req_off) begin
        sel     = APPLY_OFF;
        cnt_clr = 1'b1;
      end else if (!lit) begin
        sel     = APPLY_REQ;
        cnt_clr = 1'b1;
      end else if (safe_req) begin
        sel     = APPLY_REQ;
      end else begin
        go_hold = 1'b1;
      end
    end else if ((state_q == SEQ_HOLD) && safe_pend) begin
      sel = APPLY_PEND;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else if (go_hold) begin
      state_q <= SEQ_HOLD;
    end else if (sel == APPLY_PEND) begin
      state_q <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a   <= '0;
      pend_b   <= '0;
      pend_f   <= '0;
      pend_top <= TOP_RST;
    end else if (go_hold) begin
      pend_a   <= req_duty_a;
      pend_b   <= req_duty_b;
      pend_f   <= req_duty_f;
      pend_top <= req_top;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a <= '0;
      cmp_b <= '0;
      cmp_f <= '0;
      top_q <= TOP_RST;
      en_a  <= 1'b0;
      en_b  <= 1'b0;
    end else begin
      unique case (sel)
        APPLY_OFF: begin
          cmp_a <= '0;
          cmp_b <= '0;
          cmp_f <= '0;
          top_q <= TOP_RST;
          en_a  <= 1'b0;
          en_b  <= 1'b0;
        end
        APPLY_REQ: begin
          cmp_a <= req_duty_a;
          cmp_b <= req_duty_b;
          cmp_f <= req_duty_f;
          top_q <= req_top;
          en_a  <= (req_duty_a != '0);
          en_b  <= (req_duty_b != '0);
        end
        APPLY_PEND: begin
          cmp_a <= pend_a;
          cmp_b <= pend_b;
          cmp_f <= pend_f;
          top_q <= pend_top;
          en_a  <= (pend_a != '0);
          en_b  <= (pend_b != '0);
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/dualch_pwm_ctrl.sv
module dualch_pwm_ctrl #(
  parameter int CNT_W    = 16,
  parameter int FET_W    = 8,
  parameter int TOP_INIT = 255,
  parameter int GUARD    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_duty_a,
  input  logic [CNT_W-1:0] req_duty_b,
  input  logic [FET_W-1:0] req_duty_fet,
  input  logic [CNT_W-1:0] req_top,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             pwm_fet,
  output logic             amp_en_a,
  output logic             amp_en_b
);

  localparam int              N_LIN   = 2;
  localparam logic [FET_W-1:0] FET_TOP = {FET_W{1'b1}};

  logic [CNT_W-1:0] lin_cnt;
  logic [FET_W-1:0] fet_cnt;
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] cmp_a_q;
  logic [CNT_W-1:0] cmp_b_q;
  logic [FET_W-1:0] cmp_f_q;
  logic             cnt_clr;
  logic [CNT_W-1:0] lin_cmp [N_LIN];
  logic             lin_pwm [N_LIN];

  lpc_req_seq #(
    .CW       (CNT_W),
    .FW       (FET_W),
    .TOP_INIT (TOP_INIT),
    .GUARD    (GUARD)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_duty_a (req_duty_a),
    .req_duty_b (req_duty_b),
    .req_duty_f (req_duty_fet),
    .req_top    (req_top),
    .cnt_now    (lin_cnt),
    .cmp_a      (cmp_a_q),
    .cmp_b      (cmp_b_q),
    .cmp_f      (cmp_f_q),
    .top_q      (top_q),
    .en_a       (amp_en_a),
    .en_b       (amp_en_b),
    .cnt_clr    (cnt_clr)
  );

  lpc_updown_counter #(.W(CNT_W)) u_lin_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .top (top_q),
    .cnt (lin_cnt)
  );

  lpc_updown_counter #(.W(FET_W)) u_fet_cnt (
    .clk (clk),
    .rst (rst),
    .clr (1'b0),
    .top (FET_TOP),
    .cnt (fet_cnt)
  );

  always_comb begin
    lin_cmp[0] = cmp_a_q;
    lin_cmp[1] = cmp_b_q;
  end

  for (genvar g = 0; g < N_LIN; g++) begin : g_lin
    lpc_cmp_out #(.W(CNT_W)) u_cmp (
      .clk (clk),
      .rst (rst),
      .cnt (lin_cnt),
      .cmp (lin_cmp[g]),
      .top (top_q),
      .pwm (lin_pwm[g])
    );
  end

  lpc_cmp_out #(.W(FET_W)) u_fet_cmp (
    .clk (clk),
    .rst (rst),
    .cnt (fet_cnt),
    .cmp (cmp_f_q),
    .top (FET_TOP),
    .pwm (pwm_fet)
  );

  always_comb begin
    pwm_a = lin_pwm[0];
    pwm_b = lin_pwm[1];
  end

endmodule

// File: rtl/dualch_pwm_chk.sv
module dualch_pwm_chk #(
  parameter int CNT_W    = 16,
  parameter int FET_W    = 8,
  parameter int TOP_INIT = 255,
  parameter int GUARD    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] req_duty_a,
  input logic [CNT_W-1:0] req_duty_b,
  input logic [FET_W-1:0] req_duty_fet,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             pwm_fet,
  input logic             amp_en_a,
  input logic             amp_en_b,
  input logic [CNT_W-1:0] lin_cnt,
  input logic [CNT_W-1:0] top_q,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [FET_W-1:0] cmp_f
);

  function automatic logic [CNT_W-1:0] lim(input logic [CNT_W-1:0] t);
    return (t >= CNT_W'(GUARD)) ? (t - CNT_W'(GUARD)) : '0;
  endfunction

  logic acc;
  logic zero_req;
  logic lit;

  always_comb begin
    acc      = req_valid && req_ready;
    zero_req = (req_duty_a == '0) && (req_duty_b == '0) && (req_duty_fet == '0);
    lit      = (cmp_a != '0) || (cmp_b != '0) || (cmp_f != '0);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!amp_en_a && !amp_en_b && !pwm_a && !pwm_b && !pwm_fet && req_ready));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lin_cnt <= top_q);

  // R3
  zero_cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_a == '0 && $past(cmp_a) == '0) |-> !pwm_a);

  // R4
  fet_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_f == '0 && $past(cmp_f) == '0) |-> !pwm_fet);

  // R5
  en_off_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!amp_en_b && $past(!amp_en_b)) |-> !pwm_b);

  // R6
  off_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && zero_req) |=> (!amp_en_a && !amp_en_b && lin_cnt == '0 && top_q == CNT_W'(TOP_INIT)));

  // R7
  turn_on_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !zero_req && !lit) |=> (lin_cnt == '0));

  // R9
  top_defer_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lit) && lit && top_q != $past(top_q)) |-> ($past(lin_cnt) <= lim(top_q)));

endmodule

bind dualch_pwm_ctrl dualch_pwm_chk #(
  .CNT_W    (CNT_W),
  .FET_W    (FET_W),
  .TOP_INIT (TOP_INIT),
  .GUARD    (GUARD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_duty_a   (req_duty_a),
  .req_duty_b   (req_duty_b),
  .req_duty_fet (req_duty_fet),
  .pwm_a        (pwm_a),
  .pwm_b        (pwm_b),
  .pwm_fet      (pwm_fet),
  .amp_en_a     (amp_en_a),
  .amp_en_b     (amp_en_b),
  .lin_cnt      (lin_cnt),
  .top_q        (top_q),
  .cmp_a        (cmp_a_q),
  .cmp_b        (cmp_b_q),
  .cmp_f        (cmp_f_q)
);

// File: tb/sim_dualch_pwm_ctrl.sv
module sim_dualch_pwm_ctrl;

  localparam int CW = 16;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] da = '0;
  logic [CW-1:0] db = '0;
  logic [FW-1:0] df = '0;
  logic [CW-1:0] tp = '0;
  logic          pwm_a, pwm_b, pwm_fet, amp_en_a, amp_en_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int t_on  = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dualch_pwm_ctrl u0 (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_duty_a   (da),
    .req_duty_b   (db),
    .req_duty_fet (df),
    .req_top      (tp),
    .pwm_a        (pwm_a),
    .pwm_b        (pwm_b),
    .pwm_fet      (pwm_fet),
    .amp_en_a     (amp_en_a),
    .amp_en_b     (amp_en_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int tri_at(input int k, input int t);
    int p;
    p = k % (2 * t);
    return (p <= t) ? p : (2 * t - p);
  endfunction

  task automatic send(input int a, input int b, input int f, input int t, output int acc);
    while (!req_ready) step();
    da = CW'(a);
    db = CW'(b);
    df = FW'(f);
    tp = CW'(t);
    req_valid = 1'b1;
    step();
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic window(input int n, input int nf, output int ca, output int cb,
                        output int cf, output int first_a);
    ca = 0; cb = 0; cf = 0; first_a = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (i == 0) first_a = int'(pwm_a);
      ca += int'(pwm_a);
      cb += int'(pwm_b);
      if (i < nf) cf += int'(pwm_fet);
    end
  endtask

  task automatic test_reset();
    chk("R1 pwm_a after reset", int'(pwm_a), 0);
    chk("R1 pwm_b after reset", int'(pwm_b), 0);
    chk("R1 pwm_fet after reset", int'(pwm_fet), 0);
    chk("R1 enables after reset", int'(amp_en_a) + int'(amp_en_b), 0);
    chk("R1 ready after reset", int'(req_ready), 1);
  endtask

  task automatic test_turn_on();
    int ca, cb, cf, fa;
    send(100, 0, 60, 400, t_on);
    chk("R5 en_a with duty_a=100", int'(amp_en_a), 1);
    chk("R5 en_b with duty_b=0", int'(amp_en_b), 0);
    window(800, 510, ca, cb, cf, fa);
    chk("R7 first cycle high after turn-on", fa, 1);
    chk("R2 high count C=100 TOP=400", ca, 199);
    chk("R3 zero compare stays low", cb, 0);
    chk("R4 fet high count C=60", cf, 119);
  endtask

  task automatic test_safe_change();
    int acc, ca, cb, cf, fa;
    send(300, 400, 255, 400, acc);
    chk("R8 ready stays high on safe change", int'(req_ready), 1);
    chk("R5 en_b after duty_b=400", int'(amp_en_b), 1);
    window(800, 510, ca, cb, cf, fa);
    chk("R2 high count C=300 TOP=400", ca, 599);
    chk("R3 compare equal TOP stays high", cb, 800);
    chk("R4 fet C=255 stays high", cf, 510);
  endtask

  task automatic test_deferred();
    int acc, exp_e, guard, ca, cb, cf, fa;
    repeat (200) step();
    send(50, 0, 0, 100, acc);
    chk("R9 ready low while held", int'(req_ready), 0);
    chk("R9 old enable kept while held", int'(amp_en_b), 1);
    exp_e = acc;
    while (tri_at(exp_e - 1 - t_on, 400) > 68) exp_e++;
    guard = 0;
    while (!req_ready && guard < 2000) begin
      step();
      guard++;
    end
    chk("R9 R8 apply cycle from counter phase", cyc, exp_e);
    chk("R5 en_b drops with duty_b=0", int'(amp_en_b), 0);
    repeat (300) step();
    window(200, 0, ca, cb, cf, fa);
    chk("R2 high count C=50 TOP=100", ca, 99);
    chk("R3 channel b dark after change", cb, 0);
  endtask

  task automatic test_off();
    int acc, ca, cb, cf, fa;
    send(0, 0, 0, 999, acc);
    chk("R6 enables low after off", int'(amp_en_a) + int'(amp_en_b), 0);
    chk("R6 ready after off", int'(req_ready), 1);
    window(600, 510, ca, cb, cf, fa);
    chk("R6 pwm_a dark", ca, 0);
    chk("R6 pwm_b dark", cb, 0);
    chk("R6 pwm_fet dark", cf, 0);
  endtask

  task automatic test_turn_on_again();
    int acc, ca, cb, cf, fa;
    send(10, 0, 0, 50, acc);
    chk("R5 en_a on second turn-on", int'(amp_en_a), 1);
    window(100, 0, ca, cb, cf, fa);
    chk("R7 first cycle high on second turn-on", fa, 1);
    chk("R7 high count C=10 TOP=50", ca, 19);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    test_reset();
    test_turn_on();
    test_safe_change();
    test_deferred();
    test_off();
    test_turn_on_again();
    finish_run();
  end

endmodule